// File: doc/BRIEF.md
# I2C Write-Only Controller Engine

This block is the transmit side of an I2C bus controller. On command it produces a START condition and then sends bytes to a target, most significant bit first: first the address byte, then any number of data bytes. SCL and SDA are handled as open-drain lines. The block drives an enable that pulls the line low and reads the wired bus level back. Read transfers, repeated START and multi-controller arbitration are not handled.

After each byte the engine releases SDA for the ninth (acknowledge) clock and records whether the target pulled SDA low. It raises a one-cycle interrupt as it pulls SCL low again, whether the byte was acknowledged or not. It then parks with SCL held low. A write of the next byte into the transmit register is the only action that resumes shifting. A stop command issued while parked ends the transfer with a STOP condition.

The SCL half period comes from a divider input, counted in system clock cycles. A target may stretch SCL. After releasing SCL the engine waits until the line actually reads high, and only then starts timing the high phase.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset, `scl_oe_o` and `sda_oe_o` are 0 (both lines released), and `irq_o`, `busy_o` and `wait_o` are 0.
- R2: A `start_i` pulse while idle pulls SDA low with SCL high (START), then pulls SCL low and parks with `wait_o`=1. `start_i` at any other time is ignored.
- R3: A `stop_i` pulse while parked pulls SDA low, releases SCL, then releases SDA while SCL is high (STOP), after which `busy_o` returns to 0. `stop_i` at any other time is ignored.
- R4: A `wr_en_i` pulse while parked loads `wr_data_i` and sends its 8 bits MSB first. SDA changes only while SCL is low. `wr_en_i` at any other time is ignored. A write takes precedence over a simultaneous stop.
- R5: During the ninth clock the engine releases SDA. `ack_o` becomes 1 if SDA reads low when SCL is first seen high on that clock, and 0 otherwise. It keeps that value until the next ninth clock; a new START clears it to 0.
- R6: `irq_o` is high for exactly one cycle, the first system clock cycle in which SCL is pulled low after the ninth clock. This holds for ACK and NACK alike, and `irq_o` is never high at any other time.
- R7: After the ninth clock, SCL stays low and `wait_o` stays 1, for any length of time, until a write or a stop arrives.
- R8: Whenever the engine releases SCL it waits for `scl_i`=1 before timing the high phase. SCL therefore stays high for exactly H+1 cycles per data or acknowledge clock, whatever the length of the stretch.
- R9: The half period H equals `half_div_i`, and values below 2 are taken as 2. Between two clocks of the same byte, SCL stays low for H cycles plus any cycles the target holds it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div_i | input | DIV_W | SCL half period in clock cycles (minimum 2) |
| start_i | input | 1 | Pulse: generate START and park |
| stop_i | input | 1 | Pulse: generate STOP from the parked state |
| wr_en_i | input | 1 | Pulse: write transmit register, release the wait |
| wr_data_i | input | BYTE_W | Byte to transmit |
| scl_i | input | 1 | SCL bus level read back |
| sda_i | input | 1 | SDA bus level read back |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| irq_o | output | 1 | End-of-byte pulse |
| ack_o | output | 1 | Last acknowledge was low (ACK) |
| wait_o | output | 1 | Parked with SCL low, awaiting a write or stop |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The bench acts as a target that decodes SCL and SDA, returns ACK or NACK per byte, and stretches SCL by a chosen number of cycles. Random bytes, byte counts, divider values and stretch lengths are mixed with directed cases. Divider values 0 and 1 against 2 show the clamp. A long stretch against none shows that only the low phase grows. Mixed ACK and NACK show that the interrupt and the parking behave the same for both. Stray start, stop and write pulses during a byte and while idle show that the received bytes and the START/STOP counts are unaffected.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STA_A,   // SDA low, SCL high
    ST_STA_B,   // SCL pulled low
    ST_PARK,    // SCL low, awaiting write or stop
    ST_LOW,     // bit low phase
    ST_RISE,    // SCL released, waiting for bus high
    ST_HIGH,    // bit high phase
    ST_STO_A,   // SCL low, SDA pulled low
    ST_STO_R,   // SCL released, waiting for bus high
    ST_STO_H,   // SCL high, SDA still low
    ST_STO_F    // SDA released, bus free time
  } eng_st_e;

  localparam int unsigned MIN_HALF = 2;

  function automatic logic is_timed(eng_st_e s);
    return (s == ST_STA_A) || (s == ST_STA_B) || (s == ST_LOW) ||
           (s == ST_HIGH)  || (s == ST_STO_A) || (s == ST_STO_H) ||
           (s == ST_STO_F);
  endfunction

  function automatic logic pulls_scl(eng_st_e s);
    return (s == ST_STA_B) || (s == ST_PARK) || (s == ST_LOW) ||
           (s == ST_STO_A);
  endfunction

endpackage

// File: rtl/i2cw_half_timer.sv
module i2cw_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_i,
  input  logic             restart_i,
  input  logic             run_i,
  output logic             first_o,
  output logic             done_o
);
  import i2cw_pkg::*;

  localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign eff     = (half_i < MIN_H) ? MIN_H : half_i;
  assign first_o = (cnt_q == '0);
  assign done_o  = (cnt_q == eff - DIV_W'(1));
  assign cnt_en  = restart_i | run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (done_o) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9: a running count never passes the effective half period
  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < eff))
    else $error("half timer count out of range");

endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              step_i,
  output logic              bit_o,
  output logic              last_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              sh_en;

  assign bit_o  = sh_q[BYTE_W-1];
  assign last_o = (idx_q == LAST_IDX);
  assign sh_en  = load_i | (step_i & ~last_o);

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load_i) begin
      sh_d  = data_i;
      idx_d = '0;
    end else if (step_i && !last_o) begin
      sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  // R4: the bit index never goes past the acknowledge slot
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX)
    else $error("bit index overflow");

  // R4: a load always restarts at the first bit
  p_load_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (idx_q == '0))
    else $error("load did not restart index");

endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic wr_en_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic first_i,
  input  logic done_i,
  input  logic cur_bit_i,
  input  logic last_i,
  output logic restart_o,
  output logic run_o,
  output logic load_o,
  output logic step_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic irq_o,
  output logic ack_o,
  output logic wait_o,
  output logic busy_o
);
  import i2cw_pkg::*;

  eng_st_e state_q, state_d;
  logic    sda_q, sda_d;
  logic    irq_q, irq_d;
  logic    ack_q, ack_d;
  logic    ack_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_STA_A;
      ST_STA_A: if (done_i)  state_d = ST_STA_B;
      ST_STA_B: if (done_i)  state_d = ST_PARK;
      ST_PARK: begin
        if (wr_en_i)     state_d = ST_LOW;
        else if (stop_i) state_d = ST_STO_A;
      end
      ST_LOW:   if (done_i) state_d = ST_RISE;
      ST_RISE:  if (scl_i)  state_d = ST_HIGH;
      ST_HIGH:  if (done_i) state_d = last_i ? ST_PARK : ST_LOW;
      ST_STO_A: if (done_i) state_d = ST_STO_R;
      ST_STO_R: if (scl_i)  state_d = ST_STO_H;
      ST_STO_H: if (done_i) state_d = ST_STO_F;
      ST_STO_F: if (done_i) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  // SDA drive: updated only in the first cycle of a timed phase
  always_comb begin
    sda_d = sda_q;
    if (first_i) begin
      unique case (state_q)
        ST_STA_A: sda_d = 1'b1;
        ST_LOW:   sda_d = last_i ? 1'b0 : ~cur_bit_i;
        ST_STO_A: sda_d = 1'b1;
        ST_STO_F: sda_d = 1'b0;
        default:  sda_d = sda_q;
      endcase
    end
  end

  always_comb begin
    irq_d  = (state_q == ST_HIGH) && done_i && last_i;
    ack_en = ((state_q == ST_RISE) && scl_i && last_i) ||
             ((state_q == ST_IDLE) && start_i);
    ack_d  = ((state_q == ST_RISE) && last_i) ? ~sda_i : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sda_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sda_q   <= sda_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_q <= 1'b0;
    else if (ack_en) ack_q <= ack_d;
  end

  assign restart_o = (state_d != state_q);
  assign run_o     = is_timed(state_q);
  assign load_o    = (state_q == ST_PARK) && wr_en_i;
  assign step_o    = (state_q == ST_HIGH) && done_i;
  assign scl_oe_o  = pulls_scl(state_q);
  assign sda_oe_o  = sda_q;
  assign irq_o     = irq_q;
  assign ack_o     = ack_q;
  assign wait_o    = (state_q == ST_PARK);
  assign busy_o    = (state_q != ST_IDLE);

  // R6: the end-of-byte pulse coincides with SCL being pulled low
  p_irq_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (scl_oe_o && wait_o))
    else $error("irq without SCL held low");

  // R7: parking lasts until a write or a stop arrives
  p_park_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !wr_en_i && !stop_i) |=> wait_o)
    else $error("left park without a command");

  // R4: a write in park starts a bit low phase
  p_write_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && wr_en_i) |=> (state_q == ST_LOW))
    else $error("write did not start a byte");

  // R4: SDA steady across a high phase
  p_sda_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIGH && $past(state_q == ST_HIGH)) |-> $stable(sda_q))
    else $error("SDA moved while SCL high");

  // R5: SDA released on the acknowledge clock
  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HIGH && last_i) |-> !sda_q)
    else $error("SDA driven during acknowledge");

  // R8: no high-phase timing while SCL still reads low
  p_rise_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RISE && !scl_i) |=> (state_q == ST_RISE))
    else $error("high phase began before SCL was high");

endmodule

// File: rtl/i2c_wr_master.sv
module i2c_wr_master #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic              wait_o,
  output logic              busy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       restart, run, first, done;
  logic       load, step, cur_bit, last;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2cw_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .half_i    (half_div_i),
    .restart_i (restart),
    .run_i     (run),
    .first_o   (first),
    .done_o    (done)
  );

  i2cw_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (load),
    .data_i (wr_data_i),
    .step_i (step),
    .bit_o  (cur_bit),
    .last_o (last)
  );

  i2cw_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .wr_en_i   (wr_en_i),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .first_i   (first),
    .done_i    (done),
    .cur_bit_i (cur_bit),
    .last_i    (last),
    .restart_o (restart),
    .run_o     (run),
    .load_o    (load),
    .step_o    (step),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .irq_o     (irq_o),
    .ack_o     (ack_o),
    .wait_o    (wait_o),
    .busy_o    (busy_o)
  );

endmodule

// File: tb/i2c_wr_master_bench.sv
module i2c_wr_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int BYTE_W     = 8;
  localparam int WDOG       = 180000;

  logic              clk;
  logic              rst_n;
  logic [DIV_W-1:0]  half_div;
  logic              start_p, stop_p, wr_en;
  logic [BYTE_W-1:0] wr_data;
  logic              scl_oe, sda_oe, irq, ack, waitq, busy;
  logic              stretch_low, slv_low;
  logic              scl_bus, sda_bus;

  assign scl_bus = ~scl_oe & ~stretch_low;
  assign sda_bus = ~sda_oe & ~slv_low;

  i2c_wr_master #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_i2c_wr_master (
    .clk(clk), .rst_n(rst_n), .half_div_i(half_div),
    .start_i(start_p), .stop_i(stop_p), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .irq_o(irq), .ack_o(ack),
    .wait_o(waitq), .busy_o(busy)
  );

  int n_chk = 0, n_err = 0;
  int stretch_len = 0, stretch_cnt = 0;
  int exp_hi = 0, exp_lo = 0;
  int bcnt = 0, hi_len = 0, lo_len = 0;
  int n_start = 0, n_stop = 0, n_rx = 0, cyc = 0;
  logic [7:0] shreg;
  logic [7:0] rx_mem [0:511];
  logic prev_scl, prev_sda, ack_plan;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_half(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // target model and bus monitor
  always @(negedge clk) begin
    logic scl_now, sda_now, ninth;
    cyc++;
    if (!rst_n) begin
      stretch_low = 1'b0; slv_low = 1'b0; stretch_cnt = 0;
      prev_scl = 1'b1; prev_sda = 1'b1; bcnt = 0; shreg = '0;
    end else begin
      if (scl_oe) begin
        stretch_low = (stretch_len > 0);
        stretch_cnt = stretch_len;
      end else if (stretch_cnt > 0) begin
        stretch_cnt--;
      end else begin
        stretch_low = 1'b0;
      end
      scl_now = ~scl_oe & ~stretch_low;
      sda_now = ~sda_oe & ~slv_low;
      ninth = 1'b0;
      if (scl_now && prev_scl && prev_sda && !sda_now) begin
        n_start++; bcnt = 0;
      end else if (scl_now && prev_scl && !prev_sda && sda_now) begin
        n_stop++; bcnt = 0;
      end
      if (scl_now && !prev_scl) begin
        if (bcnt >= 1 && bcnt <= 8)
          chk(lo_len == exp_lo, "R9 low phase length", lo_len, exp_lo);
        if (bcnt < 8) shreg = {shreg[6:0], sda_now};
        bcnt++;
        hi_len = 1;
      end else if (scl_now) begin
        hi_len++;
      end
      if (!scl_now && prev_scl) begin
        if (bcnt >= 1 && bcnt <= 9)
          chk(hi_len == exp_hi, "R8 high phase length", hi_len, exp_hi);
        if (bcnt == 8) slv_low = ack_plan;
        if (bcnt == 9) begin
          rx_mem[n_rx[8:0]] = shreg;
          n_rx++;
          slv_low = 1'b0;
          bcnt = 0;
          ninth = 1'b1;
        end
        lo_len = 1;
      end else if (!scl_now) begin
        lo_len++;
      end
      if (ninth || irq)
        chk(irq == ninth, "R6 irq at ninth falling edge", int'(irq), int'(ninth));
      prev_scl = scl_now;
      prev_sda = sda_now;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_p = 1'b1; @(negedge clk); start_p = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_p = 1'b1; @(negedge clk); stop_p = 1'b0;
  endtask
  task automatic pulse_wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d; @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_txn(input int div, input int nbytes, input int s, input bit probe);
    int b_start, b_stop, b_rx, hold;
    bit held;
    logic [7:0] d;
    half_div = DIV_W'(div);
    stretch_len = s;
    exp_hi = eff_half(div) + 1;
    exp_lo = eff_half(div) + s;
    b_start = n_start; b_stop = n_stop;
    pulse_start();
    while (!waitq) @(negedge clk);
    #1;
    chk(n_start == b_start + 1, "R2 START seen then park", n_start, b_start + 1);
    chk(ack == 1'b0, "R5 ack cleared by START", int'(ack), 0);
    for (int b = 0; b < nbytes; b++) begin
      d = 8'($urandom);
      ack_plan = 1'($urandom);
      b_rx = n_rx;
      pulse_wr(d);
      if (probe) begin
        repeat (3) @(negedge clk);
        pulse_wr(~d);
        pulse_stop();
        pulse_start();
      end
      while (!irq) @(negedge clk);
      #1;
      chk(n_rx == b_rx + 1, "R4 one byte per write", n_rx, b_rx + 1);
      chk(rx_mem[b_rx[8:0]] == d, "R4 byte MSB first", int'(rx_mem[b_rx[8:0]]), int'(d));
      chk(ack == ack_plan, "R5 ack sampled", int'(ack), int'(ack_plan));
      hold = $urandom_range(0, 15);
      held = 1'b1;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk); #1;
        if (!waitq || scl_bus) held = 1'b0;
      end
      chk(held && waitq && !scl_bus, "R7 SCL held low while parked", int'(held), 1);
    end
    pulse_stop();
    while (busy) @(negedge clk);
    #1;
    chk(n_stop == b_stop + 1, "R3 one STOP per transfer", n_stop, b_stop + 1);
    chk(n_start == b_start + 1, "R2 stray start ignored", n_start, b_start + 1);
    chk(!scl_oe && !sda_oe, "R3 lines released after STOP", int'({scl_oe, sda_oe}), 0);
  endtask

  initial begin
    rst_n = 1'b0; half_div = '0; start_p = 1'b0; stop_p = 1'b0;
    wr_en = 1'b0; wr_data = '0; ack_plan = 1'b0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!scl_oe && !sda_oe, "R1 lines released", int'({scl_oe, sda_oe}), 0);
    chk(!irq && !busy && !waitq, "R1 flags clear", int'({irq, busy, waitq}), 0);

    // stray write and stop while idle
    half_div = 8'd3;
    pulse_wr(8'hA5);
    pulse_stop();
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !scl_oe && !sda_oe, "R4 idle write ignored", int'({busy, scl_oe, sda_oe}), 0);
    chk(n_stop == 0 && n_start == 0, "R3 idle stop ignored", n_stop + n_start, 0);

    // directed: clamp, nominal, long stretch, large divider, stray commands
    run_txn(0, 2, 0, 1'b0);
    run_txn(1, 2, 1, 1'b0);
    run_txn(2, 3, 0, 1'b1);
    run_txn(4, 2, 7, 1'b1);
    run_txn(200, 1, 2, 1'b0);

    // write wins over a simultaneous stop
    half_div = 8'd3; stretch_len = 0; exp_hi = 4; exp_lo = 3;
    pulse_start();
    while (!waitq) @(negedge clk);
    @(negedge clk); wr_en = 1'b1; stop_p = 1'b1; wr_data = 8'h3C;
    @(negedge clk); wr_en = 1'b0; stop_p = 1'b0;
    #1;
    chk(busy && !waitq, "R4 write has precedence over stop", int'({busy, waitq}), 2);
    while (!irq) @(negedge clk);
    #1;
    chk(rx_mem[(n_rx - 1) & 511] == 8'h3C, "R4 precedence byte", int'(rx_mem[(n_rx - 1) & 511]), 8'h3C);
    pulse_stop();
    while (busy) @(negedge clk);

    // constrained random transfers
    for (int t = 0; t < 25; t++)
      run_txn($urandom_range(0, 9), $urandom_range(1, 4),
              $urandom_range(0, 4), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WDOG);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule